// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailboxes and Collision Flags

This block is a synchronous true dual-port memory with two ports, left and right. Both ports run on one clock. Each port has two chip enables, a write strobe, one byte-lane select per 9-bit lane, an address and separate write and read data buses. Any port can read or write any word. Reads pass through a two-stage output pipeline.

Two features sit on top of the storage. The two highest words act as mailboxes. When one port writes the mailbox word that belongs to the other port, the other port gets an active-low interrupt. That interrupt stays asserted until its owner reads the word. The block also watches for both ports selecting the same address in the same cycle. Each such cycle produces a one-cycle busy pulse on both ports, a fixed number of cycles later. The pulse lets software or a neighbouring arbiter find out that the two ports raced on one location.

Top module: `dpr_mbox_ram`

## Requirements
- R1: A port is selected in a cycle only when its ce0_n is 0 and its ce1 is 1. An unselected port writes nothing, does not change its rdata, does not touch any mailbox flag and takes no part in a collision.
- R2: A selected write with we=1 stores only the lanes whose be bit is 1. Lane i is data bits [9i+8:9i]. Unselected lanes keep their old contents.
- R3: A selected read with we=0 is sampled at clock edge e, and its rdata appears after edge e+2. Lanes whose be bit is 1 carry the stored data and the other lanes read as zero. rdata holds its value when no read was sampled two edges earlier.
- R4: A read sampled at the same edge as a write to the same address returns the old contents. A read sampled at any later edge returns the new contents.
- R5: When both ports write the same lane of the same address at one edge, the left port's data is stored.
- R6: The left mailbox is address DEPTH-1 and the right mailbox is address DEPTH-2. A selected write by the other port to a port's mailbox drives that port's int_n to 0 after edge e+1. A port writing its own mailbox does not change its own int_n.
- R7: A selected read by a port of its own mailbox drives its int_n back to 1 after edge e+1. If the other port writes that mailbox at the same edge, the interrupt stays asserted.
- R8: A collision exists when both ports are selected with equal addresses, whatever they read or write. A collision sampled at edge e makes l_busy and r_busy both 1 from edge e+5 to edge e+6, and busy is 0 in every other cycle.
- R9: While reset is applied, and until it has been released through two clock edges, int_n is 1, busy is 0 and rdata is zero on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_be | input | LANES | Left byte-lane selects |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | LANES*LANE_W | Left write data |
| l_rdata | output | LANES*LANE_W | Left read data |
| l_busy | output | 1 | Left collision pulse |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_be | input | LANES | Right byte-lane selects |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | LANES*LANE_W | Right write data |
| r_rdata | output | LANES*LANE_W | Right read data |
| r_busy | output | 1 | Right collision pulse |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
A corrupted request register shows up at the ports quickly. A read shows it on rdata two edges after the bad sample, and a write shows it on the first later read of the word. A mailbox flag in the wrong state is visible on int_n at the next sample. It then stays wrong until the next set or clear event, so a mailbox test must both set and clear each flag. An error in the busy delay line shows as a pulse that is missing, doubled or shifted within six cycles of a collision. Checking every port output against a cycle model, on every cycle, catches each of these at the first cycle where the error can be seen.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Operation held in the request register of one port
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } op_e;

  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/dpr_port_front.sv
module dpr_port_front
  import dpr_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 8,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] be_q,
  output logic [DW-1:0]    wdata_q
);

  logic             sel;
  op_e              op_d;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] be_d;
  logic [DW-1:0]    wdata_d;

  // Both enables must agree before the port does anything
  assign sel = !ce0_n && ce1;

  always_comb begin
    op_d    = OP_NONE;
    addr_d  = addr_q;
    be_d    = be_q;
    wdata_d = wdata_q;
    if (sel) begin
      op_d    = we ? OP_WRITE : OP_READ;
      addr_d  = addr;
      be_d    = be;
      wdata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      be_q    <= be_d;
      wdata_q <= wdata_d;
    end
  end

endmodule

// File: rtl/dpr_core.sv
module dpr_core
  import dpr_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 8,
  parameter int LW    = 9,
  localparam int DW    = LANES * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op_l,
  input  logic [AW-1:0]    addr_l,
  input  logic [LANES-1:0] be_l,
  input  logic [DW-1:0]    wdata_l,
  input  op_e              op_r,
  input  logic [AW-1:0]    addr_r,
  input  logic [LANES-1:0] be_r,
  input  logic [DW-1:0]    wdata_r,
  output logic [DW-1:0]    rdata_l,
  output logic [DW-1:0]    rdata_r
);

  logic [DW-1:0] mem [DEPTH];

  // Right lanes are written first so that the left port overrides on a tie
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (op_r == OP_WRITE && be_r[i]) begin
        mem[addr_r][i*LW +: LW] <= wdata_r[i*LW +: LW];
      end
    end
    for (int i = 0; i < LANES; i++) begin
      if (op_l == OP_WRITE && be_l[i]) begin
        mem[addr_l][i*LW +: LW] <= wdata_l[i*LW +: LW];
      end
    end
  end

  // Two-stage read pipeline per port: array sample, then output register
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    op_e              op_p;
    logic [AW-1:0]    addr_p;
    logic [LANES-1:0] be_p;
    logic [DW-1:0]    lane_d;
    logic             vld_d;
    logic             vld_q;
    logic [DW-1:0]    stg_d;
    logic [DW-1:0]    stg_q;
    logic [DW-1:0]    out_d;
    logic [DW-1:0]    out_q;

    assign op_p   = (p == PORT_L) ? op_l   : op_r;
    assign addr_p = (p == PORT_L) ? addr_l : addr_r;
    assign be_p   = (p == PORT_L) ? be_l   : be_r;

    always_comb begin
      lane_d = '0;
      for (int i = 0; i < LANES; i++) begin
        if (be_p[i]) begin
          lane_d[i*LW +: LW] = mem[addr_p][i*LW +: LW];
        end
      end
    end

    always_comb begin
      vld_d = (op_p == OP_READ);
      stg_d = vld_d ? lane_d : stg_q;
      out_d = vld_q ? stg_q : out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        stg_q <= '0;
        out_q <= '0;
      end else begin
        vld_q <= vld_d;
        stg_q <= stg_d;
        out_q <= out_d;
      end
    end
  end

  assign rdata_l = g_rd[PORT_L].out_q;
  assign rdata_r = g_rd[PORT_R].out_q;

endmodule

// File: rtl/dpr_mailbox.sv
module dpr_mailbox
  import dpr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_l,
  input  logic [AW-1:0] addr_l,
  input  op_e           op_r,
  input  logic [AW-1:0] addr_r,
  output logic          int_l_n,
  output logic          int_r_n
);

  localparam logic [AW-1:0] MBOX_L = {AW{1'b1}};
  localparam logic [AW-1:0] MBOX_R = {{(AW-1){1'b1}}, 1'b0};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mb
    localparam logic [AW-1:0] OWN = (p == PORT_L) ? MBOX_L : MBOX_R;

    op_e           own_op;
    logic [AW-1:0] own_addr;
    op_e           far_op;
    logic [AW-1:0] far_addr;
    logic          set_ev;
    logic          clr_ev;
    logic          pend_d;
    logic          pend_q;

    assign own_op   = (p == PORT_L) ? op_l   : op_r;
    assign own_addr = (p == PORT_L) ? addr_l : addr_r;
    assign far_op   = (p == PORT_L) ? op_r   : op_l;
    assign far_addr = (p == PORT_L) ? addr_r : addr_l;

    assign set_ev = (far_op == OP_WRITE) && (far_addr == OWN);
    assign clr_ev = (own_op == OP_READ)  && (own_addr == OWN);

    // A new message outranks an acknowledge in the same cycle
    always_comb begin
      pend_d = pend_q;
      if (set_ev) begin
        pend_d = 1'b1;
      end else if (clr_ev) begin
        pend_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
      end
    end
  end

  assign int_l_n = ~g_mb[PORT_L].pend_q;
  assign int_r_n = ~g_mb[PORT_R].pend_q;

endmodule

// File: rtl/dpr_collide.sv
module dpr_collide
  import dpr_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_l,
  input  logic [AW-1:0] addr_l,
  input  op_e           op_r,
  input  logic [AW-1:0] addr_r,
  output logic          busy
);

  logic           hit;
  logic [LAT-1:0] line_d;
  logic [LAT-1:0] line_q;

  assign hit = (op_l != OP_NONE) && (op_r != OP_NONE) && (addr_l == addr_r);

  always_comb begin
    line_d = {line_q[LAT-2:0], hit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  assign busy = line_q[LAT-1];

endmodule

// File: rtl/dpr_mbox_ram.sv
module dpr_mbox_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 8,
  parameter int LANE_W   = 9,
  parameter int BUSY_LAT = 5,
  localparam int DW      = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce0_n,
  input  logic              l_ce1,
  input  logic              l_we,
  input  logic [LANES-1:0]  l_be,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DW-1:0]     l_wdata,
  output logic [DW-1:0]     l_rdata,
  output logic              l_busy,
  output logic              l_int_n,
  input  logic              r_ce0_n,
  input  logic              r_ce1,
  input  logic              r_we,
  input  logic [LANES-1:0]  r_be,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DW-1:0]     r_wdata,
  output logic [DW-1:0]     r_rdata,
  output logic              r_busy,
  output logic              r_int_n
);

  logic              rst_s;
  op_e               op_lq;
  op_e               op_rq;
  logic [ADDR_W-1:0] addr_lq;
  logic [ADDR_W-1:0] addr_rq;
  logic [LANES-1:0]  be_lq;
  logic [LANES-1:0]  be_rq;
  logic [DW-1:0]     wdata_lq;
  logic [DW-1:0]     wdata_rq;
  logic              busy_w;

  dpr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  dpr_port_front #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_front_l (
    .clk     (clk),
    .rst_n   (rst_s),
    .ce0_n   (l_ce0_n),
    .ce1     (l_ce1),
    .we      (l_we),
    .be      (l_be),
    .addr    (l_addr),
    .wdata   (l_wdata),
    .op_q    (op_lq),
    .addr_q  (addr_lq),
    .be_q    (be_lq),
    .wdata_q (wdata_lq)
  );

  dpr_port_front #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_front_r (
    .clk     (clk),
    .rst_n   (rst_s),
    .ce0_n   (r_ce0_n),
    .ce1     (r_ce1),
    .we      (r_we),
    .be      (r_be),
    .addr    (r_addr),
    .wdata   (r_wdata),
    .op_q    (op_rq),
    .addr_q  (addr_rq),
    .be_q    (be_rq),
    .wdata_q (wdata_rq)
  );

  dpr_core #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_s),
    .op_l    (op_lq),
    .addr_l  (addr_lq),
    .be_l    (be_lq),
    .wdata_l (wdata_lq),
    .op_r    (op_rq),
    .addr_r  (addr_rq),
    .be_r    (be_rq),
    .wdata_r (wdata_rq),
    .rdata_l (l_rdata),
    .rdata_r (r_rdata)
  );

  dpr_mailbox #(.AW(ADDR_W)) u_mbox (
    .clk     (clk),
    .rst_n   (rst_s),
    .op_l    (op_lq),
    .addr_l  (addr_lq),
    .op_r    (op_rq),
    .addr_r  (addr_rq),
    .int_l_n (l_int_n),
    .int_r_n (r_int_n)
  );

  dpr_collide #(.AW(ADDR_W), .LAT(BUSY_LAT)) u_coll (
    .clk    (clk),
    .rst_n  (rst_s),
    .op_l   (op_lq),
    .addr_l (addr_lq),
    .op_r   (op_rq),
    .addr_r (addr_rq),
    .busy   (busy_w)
  );

  assign l_busy = busy_w;
  assign r_busy = busy_w;

endmodule

// File: rtl/dpr_mbox_ram_chk.sv
module dpr_mbox_ram_chk #(
  parameter int AW     = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          l_ce0_n,
  input logic          l_ce1,
  input logic          l_we,
  input logic          l_be0,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy,
  input logic          l_int_n,
  input logic          r_ce0_n,
  input logic          r_ce1,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic          r_busy,
  input logic          r_int_n
);

  localparam logic [AW-1:0] MB_L = {AW{1'b1}};
  localparam logic [AW-1:0] MB_R = {{(AW-1){1'b1}}, 1'b0};

  logic l_sel, r_sel, l_rd, l_wr, r_wr, coll_in;

  assign l_sel   = !l_ce0_n && l_ce1;
  assign r_sel   = !r_ce0_n && r_ce1;
  assign l_rd    = l_sel && !l_we;
  assign l_wr    = l_sel && l_we;
  assign r_wr    = r_sel && r_we;
  assign coll_in = l_sel && r_sel && (l_addr == r_addr);

  // R8
  collision_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    coll_in |-> ##6 (l_busy && r_busy));

  // R8
  quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !coll_in |-> ##6 (!l_busy && !r_busy));

  // R6
  left_mbox_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (r_wr && r_addr == MB_L) |=> ##1 !l_int_n);

  // R6
  right_mbox_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (l_wr && l_addr == MB_R) |=> ##1 !r_int_n);

  // R7
  left_mbox_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (l_rd && l_addr == MB_L && !(r_wr && r_addr == MB_L)) |=> ##1 l_int_n);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !l_rd |=> ##2 $stable(l_rdata));

  // R3
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (l_rd && !l_be0) |=> ##2 (l_rdata[LANE_W-1:0] == '0));

endmodule

bind dpr_mbox_ram dpr_mbox_ram_chk #(
  .AW     (ADDR_W),
  .LANES  (LANES),
  .LANE_W (LANE_W)
) u_chk (
  .clk     (clk),
  .rst_sn  (rst_s),
  .l_ce0_n (l_ce0_n),
  .l_ce1   (l_ce1),
  .l_we    (l_we),
  .l_be0   (l_be[0]),
  .l_addr  (l_addr),
  .l_rdata (l_rdata),
  .l_busy  (l_busy),
  .l_int_n (l_int_n),
  .r_ce0_n (r_ce0_n),
  .r_ce1   (r_ce1),
  .r_we    (r_we),
  .r_addr  (r_addr),
  .r_busy  (r_busy),
  .r_int_n (r_int_n)
);

// File: tb/tb_dpr_mbox_ram.sv
module tb_dpr_mbox_ram;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int LANES = 8;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MB_L = AW'(DEPTH - 1);
  localparam logic [AW-1:0] MB_R = AW'(DEPTH - 2);

  logic clk, rst_n;
  logic l_ce0_n, l_ce1, l_we, r_ce0_n, r_ce1, r_we;
  logic [LANES-1:0] l_be, r_be;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_busy, r_busy, l_int_n, r_int_n;

  dpr_mbox_ram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW), .BUSY_LAT(5)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_we(l_we), .l_be(l_be), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy(l_busy), .l_int_n(l_int_n),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_we(r_we), .r_be(r_be), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy(r_busy), .r_int_n(r_int_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    cmp_en = 0;
  bit    done = 0;
  string tag = "R9 reset";

  task automatic chk(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] lanes_of(logic [DW-1:0] d, logic [LANES-1:0] be);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) if (be[i]) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [LANES-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LANES; i++) if (be[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] init_word(int a);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LW +: LW] = LW'(a * 8 + i + 1);
    return r;
  endfunction

  // ---------------- cycle model built from the requirements ----------------
  logic [DW-1:0]    m_mem [DEPTH];
  int               m_aop [2];
  logic [AW-1:0]    m_aaddr [2];
  logic [LANES-1:0] m_abe [2];
  logic [DW-1:0]    m_awd [2];
  logic             m_v1 [2];
  logic [DW-1:0]    m_rd1 [2];
  logic [DW-1:0]    m_rdx [2];
  logic             m_pend [2];
  logic [4:0]       m_sh;
  logic             m_s1, m_s2;

  task automatic m_reset();
    for (int p = 0; p < 2; p++) begin
      m_aop[p] = 0; m_aaddr[p] = '0; m_abe[p] = '0; m_awd[p] = '0;
      m_v1[p] = 0; m_rd1[p] = '0; m_rdx[p] = '0; m_pend[p] = 0;
    end
    m_sh = '0;
  endtask

  task automatic m_step();
    logic hit;
    logic [AW-1:0] own;
    logic set_e, clr_e;
    for (int p = 0; p < 2; p++) if (m_v1[p]) m_rdx[p] = m_rd1[p];
    for (int p = 0; p < 2; p++) begin
      m_v1[p] = (m_aop[p] == 1);
      if (m_aop[p] == 1) m_rd1[p] = lanes_of(m_mem[m_aaddr[p]], m_abe[p]);
    end
    // right first, left overrides (R5)
    if (m_aop[1] == 2) m_mem[m_aaddr[1]] = merge(m_mem[m_aaddr[1]], m_awd[1], m_abe[1]);
    if (m_aop[0] == 2) m_mem[m_aaddr[0]] = merge(m_mem[m_aaddr[0]], m_awd[0], m_abe[0]);
    for (int p = 0; p < 2; p++) begin
      own   = (p == 0) ? MB_L : MB_R;
      set_e = (m_aop[1-p] == 2) && (m_aaddr[1-p] == own);
      clr_e = (m_aop[p] == 1) && (m_aaddr[p] == own);
      if (set_e) m_pend[p] = 1;
      else if (clr_e) m_pend[p] = 0;
    end
    hit = (m_aop[0] != 0) && (m_aop[1] != 0) && (m_aaddr[0] == m_aaddr[1]);
    m_sh = {m_sh[3:0], hit};
    if (!l_ce0_n && l_ce1) begin
      m_aop[0] = l_we ? 2 : 1; m_aaddr[0] = l_addr; m_abe[0] = l_be; m_awd[0] = l_wdata;
    end else m_aop[0] = 0;
    if (!r_ce0_n && r_ce1) begin
      m_aop[1] = r_we ? 2 : 1; m_aaddr[1] = r_addr; m_abe[1] = r_be; m_awd[1] = r_wdata;
    end else m_aop[1] = 0;
  endtask

  always @(posedge clk) begin
    logic in_rst;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_reset();
    end else begin
      in_rst = !m_s2;
      m_s2 = m_s1; m_s1 = 1;
      if (in_rst) m_reset(); else m_step();
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("l_rdata", l_rdata, m_rdx[0]);
      chk("r_rdata", r_rdata, m_rdx[1]);
      chk("l_int_n", DW'(l_int_n), DW'(!m_pend[0]));
      chk("r_int_n", DW'(r_int_n), DW'(!m_pend[1]));
      chk("l_busy",  DW'(l_busy),  DW'(m_sh[4]));
      chk("r_busy",  DW'(r_busy),  DW'(m_sh[4]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(int p, bit ce0n, bit ce1, bit we, logic [LANES-1:0] be,
                     logic [AW-1:0] a, logic [DW-1:0] d);
    if (p == 0) begin
      l_ce0_n = ce0n; l_ce1 = ce1; l_we = we; l_be = be; l_addr = a; l_wdata = d;
    end else begin
      r_ce0_n = ce0n; r_ce1 = ce1; r_we = we; r_be = be; r_addr = a; r_wdata = d;
    end
  endtask

  task automatic idle_both();
    drv(0, 1, 0, 0, '0, '0, '0);
    drv(1, 1, 0, 0, '0, '0, '0);
  endtask

  task automatic cyc_wr(int p, logic [LANES-1:0] be, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); idle_both(); drv(p, 0, 1, 1, be, a, d);
  endtask

  task automatic read_chk(int p, logic [AW-1:0] a, logic [LANES-1:0] be,
                          logic [DW-1:0] exp, string what);
    @(negedge clk); idle_both(); drv(p, 0, 1, 0, be, a, '0);
    @(negedge clk); idle_both();
    @(negedge clk);
    @(negedge clk);
    chk(what, (p == 0) ? l_rdata : r_rdata, exp);
  endtask

  task automatic settle_chk_int(int p, logic exp, string what);
    @(negedge clk); idle_both();
    @(negedge clk);
    chk(what, DW'((p == 0) ? l_int_n : r_int_n), DW'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d1, d2;
    void'($urandom(32'd4242));
    rst_n = 1'b1;
    idle_both();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp_en = 1;
    // R9: reset values
    chk("R9 l_int_n", DW'(l_int_n), DW'(1'b1));
    chk("R9 r_busy", DW'(r_busy), DW'(1'b0));
    chk("R9 l_rdata", l_rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R2 init";
    for (int a = 0; a < DEPTH; a++) cyc_wr(0, '1, AW'(a), init_word(a));
    @(negedge clk); idle_both();
    repeat (3) @(negedge clk);

    tag = "R1 select";
    @(negedge clk); idle_both(); drv(0, 1, 1, 1, '1, 6'd5, '1);
    @(negedge clk); idle_both(); drv(1, 0, 0, 1, '1, 6'd5, '1);
    read_chk(0, 6'd5, '1, init_word(5), "R1 unselected writes ignored");

    tag = "R2 lanes";
    d1 = {LANES{9'h1A5}};
    cyc_wr(0, 8'h0F, 6'd7, d1);
    read_chk(1, 6'd7, '1, merge(init_word(7), d1, 8'h0F), "R2 partial lane write");

    tag = "R3 read lanes";
    read_chk(0, 6'd3, 8'hF0, lanes_of(init_word(3), 8'hF0), "R3 unselected lanes zero");

    tag = "R4 write-read same cycle";
    d2 = {LANES{9'h0C3}};
    @(negedge clk); idle_both(); drv(0, 0, 1, 1, '1, 6'd9, d2); drv(1, 0, 1, 0, '1, 6'd9, '0);
    @(negedge clk); idle_both();
    @(negedge clk);
    @(negedge clk);
    chk("R4 old data on same-cycle read", r_rdata, init_word(9));
    read_chk(1, 6'd9, '1, d2, "R4 new data next read");

    tag = "R5 double write";
    @(negedge clk); idle_both(); drv(0, 0, 1, 1, '1, 6'd10, d1); drv(1, 0, 1, 1, '1, 6'd10, d2);
    read_chk(0, 6'd10, '1, d1, "R5 left wins");

    tag = "R6 mailbox set";
    cyc_wr(1, 8'h01, MB_L, d1);
    settle_chk_int(0, 1'b0, "R6 left int asserted");
    tag = "R7 mailbox clear";
    @(negedge clk); idle_both(); drv(0, 0, 1, 0, '1, MB_L, '0);
    settle_chk_int(0, 1'b1, "R7 left int cleared");
    cyc_wr(0, '1, MB_L, d2);
    settle_chk_int(0, 1'b1, "R6 own write no effect");
    @(negedge clk); idle_both(); drv(1, 0, 1, 0, '1, MB_R, '0);
    settle_chk_int(1, 1'b1, "R7 right int cleared");
    @(negedge clk); idle_both(); drv(0, 0, 1, 0, '1, MB_L, '0); drv(1, 0, 1, 1, '1, MB_L, d1);
    settle_chk_int(0, 1'b0, "R7 set beats clear");
    @(negedge clk); idle_both(); drv(0, 0, 1, 0, '1, MB_L, '0);
    settle_chk_int(0, 1'b1, "R7 cleared again");

    tag = "R8 collision";
    @(negedge clk); idle_both(); drv(0, 0, 1, 0, '1, 6'd20, '0); drv(1, 0, 1, 1, '1, 6'd20, d1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); idle_both();
      chk($sformatf("R8 busy at cycle %0d", k), DW'(l_busy && r_busy), DW'(k == 6));
    end
    @(negedge clk); idle_both(); drv(0, 0, 1, 0, '1, 6'd21, '0); drv(1, 0, 1, 0, '1, 6'd22, '0);
    @(negedge clk); idle_both(); drv(0, 0, 1, 0, '1, 6'd23, '0); drv(1, 1, 1, 0, '1, 6'd23, '0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); idle_both();
      chk("R8 no busy without collision", DW'(l_busy || r_busy), DW'(1'b0));
    end

    tag = "R3/R6/R8 random";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        logic [AW-1:0] a;
        logic [LANES-1:0] be;
        if (($urandom % 4) == 0) a = ($urandom % 2) ? MB_L : MB_R;
        else a = AW'($urandom % 8);
        be = (($urandom % 3) == 0) ? LANES'($urandom) : '1;
        drv(p, ($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2, be, a,
            {8'($urandom), 32'($urandom), 32'($urandom)});
      end
    end
    @(negedge clk); idle_both();
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule